// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Stage

This block is a small single-accumulator processor. It steps through a fetch stage, an execute stage and an interrupt-check stage against a word-addressed synchronous memory held inside the block. The architectural state is a program counter, an instruction register, a 16-bit accumulator, a stack pointer and a 16-bit status word. Bit 0 of the status word is the interrupt enable and bit 1 is the carry.

Each 16-bit instruction carries an opcode in bits 15:12 and an operand address in bits 11:0. The instruction set has load, add, store, halt and return-from-interrupt. A single interrupt request line is sampled only once an instruction has fully completed, and only while interrupts are enabled. Taking the request saves the PC and then the status word on a downward-growing stack in memory, clears the enable, and jumps to a fixed handler. Returning pops both values and resumes the interrupted program.

While reset is held, the bench fills memory through a load port. A registered debug read port shows any memory word at any time.

Top module: `accIrqCpu`

## Requirements
- R1: While reset is held, the outputs are pc = 0x300, acc = 0x0000, status = 0x0001, done = 0 and intAck = 0.
- R2: Opcode 0x1 loads acc from the operand address. Opcode 0x5 adds the word at that address to acc. Opcode 0x2 writes acc to that address. The program 0x1940, 0x5941, 0x2941 with 0x0003 at 0x940 and 0x0002 at 0x941 leaves 0x0005 at 0x941.
- R3: Instruction timing is fixed:
  - load and add take 5 cycles;
  - store and no-op take 4 cycles;
  - halt raises done 3 cycles after its fetch begins.
- R4: Every fetch increments the PC by one, so after a halt the PC holds the halt's address plus one.
- R5: Opcodes other than 0x1, 0x2, 0x5, 0xE and 0xF change neither acc, the status word nor memory.
- R6: Add writes its carry-out into status bit 1. Load and store leave that bit unchanged.
- R7: A pending request is taken only after an instruction completes and while status bit 0 is 1. When it is taken:
  - the PC is written to the stack slot 0xFFF and the status word to 0xFFE;
  - intAck pulses for one cycle, 6 cycles after a load begins;
  - the PC becomes 0x100 and status bit 0 clears.
- R8: While status bit 0 is 0, the request line is ignored: no acknowledge is given and no stack word is written.
- R9: Opcode 0xE pops the status word and then the PC, restoring the interrupt enable and resuming at the instruction after the interrupted one.
- R10: Opcode 0xF raises done, which stays high. After that the PC stays fixed, memory is never written, and no interrupt is taken.
- R11: While reset is held, loadEn writes loadData to loadAddr. dbgData shows the word at dbgAddr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables memory preload |
| irq | input | 1 | Interrupt request level |
| loadEn | input | 1 | Preload write strobe (honoured during reset) |
| loadAddr | input | 12 | Preload address |
| loadData | input | 16 | Preload data |
| dbgAddr | input | 12 | Debug read address |
| dbgData | output | 16 | Debug read data, one cycle latency |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| status | output | 16 | Status word (bit 0 enable, bit 1 carry) |
| done | output | 1 | Processor halted |
| intAck | output | 1 | One-cycle interrupt acknowledge |

## Verification
Cycles are counted from the first rising edge after reset is released. For each program the bench computes the due cycle by adding the per-opcode costs: 5 for load and add, 4 for store and no-op, 3 for halt, and 2 for an interrupt entry after the instruction it follows. A straight load, add, store and halt must therefore raise done on edge 17, and an acknowledge after an opening load must appear on edge 6. The bench advances one edge at a time and samples on the falling edge that follows, so the recorded edge count is compared exactly with the computed value. Memory results are read through the debug port only after done, each one sampled a full cycle after its address is set.

// File: rtl/accPkg.sv
package accPkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = 4;

  localparam int IE_BIT    = 0;
  localparam int CARRY_BIT = 1;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OP_W-1:0] OP_RTI   = 4'hE;
  localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [3:0] {
    S_FETCH, S_FWAIT, S_EXEC, S_EWAIT, S_CHECK,
    S_PUSHPC, S_PUSHST, S_RTIST, S_RTIPC, S_HALT
  } state_e;

  typedef enum logic [1:0] {A_PC, A_OPER, A_SP, A_SPUP} addrSel_e;
  typedef enum logic [1:0] {W_ACC, W_PC, W_STATUS} wSel_e;

  typedef struct packed {
    addrSel_e addrSel;
    logic     memWe;
    wSel_e    wSel;
    logic     irLoad;
    logic     pcInc;
    logic     pcVector;
    logic     pcFromMem;
    logic     accLoad;
    logic     accAdd;
    logic     spDec;
    logic     spInc;
    logic     statusFromMem;
    logic     ieClear;
  } strobe_t;
endpackage

// File: rtl/accMem.sv
module accMem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] dbgAddr,
  output logic [DW-1:0] dbgData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata   <= cells[addr];
    dbgData <= cells[dbgAddr];
  end
endmodule

// File: rtl/accControl.sv
module accControl
  import accPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            irq,
  input  logic [OP_W-1:0] opcode,
  input  logic            ieFlag,
  output strobe_t         strb,
  output logic            done,
  output logic            intAck
);
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    strb      = '0;
    intAck    = 1'b0;
    nextState = state;
    unique case (state)
      S_FETCH: begin
        strb.addrSel = A_PC;
        nextState    = S_FWAIT;
      end
      S_FWAIT: begin
        strb.irLoad = 1'b1;
        strb.pcInc  = 1'b1;
        nextState   = S_EXEC;
      end
      S_EXEC: begin
        if (opcode == OP_LOAD || opcode == OP_ADD) begin
          strb.addrSel = A_OPER;
          nextState    = S_EWAIT;
        end else if (opcode == OP_STORE) begin
          strb.addrSel = A_OPER;
          strb.memWe   = 1'b1;
          strb.wSel    = W_ACC;
          nextState    = S_CHECK;
        end else if (opcode == OP_RTI) begin
          strb.addrSel = A_SPUP;
          strb.spInc   = 1'b1;
          nextState    = S_RTIST;
        end else if (opcode == OP_HALT) begin
          nextState = S_HALT;
        end else begin
          nextState = S_CHECK;
        end
      end
      S_EWAIT: begin
        if (opcode == OP_LOAD) strb.accLoad = 1'b1;
        else                   strb.accAdd  = 1'b1;
        nextState = S_CHECK;
      end
      S_CHECK: begin
        nextState = (ieFlag && irq) ? S_PUSHPC : S_FETCH;
      end
      S_PUSHPC: begin
        strb.addrSel = A_SP;
        strb.memWe   = 1'b1;
        strb.wSel    = W_PC;
        strb.spDec   = 1'b1;
        nextState    = S_PUSHST;
      end
      S_PUSHST: begin
        strb.addrSel  = A_SP;
        strb.memWe    = 1'b1;
        strb.wSel     = W_STATUS;
        strb.spDec    = 1'b1;
        strb.pcVector = 1'b1;
        strb.ieClear  = 1'b1;
        intAck        = 1'b1;
        nextState     = S_FETCH;
      end
      S_RTIST: begin
        strb.statusFromMem = 1'b1;
        strb.addrSel       = A_SPUP;
        strb.spInc         = 1'b1;
        nextState          = S_RTIPC;
      end
      S_RTIPC: begin
        strb.pcFromMem = 1'b1;
        nextState      = S_CHECK;
      end
      S_HALT: nextState = S_HALT;
      default: nextState = S_FETCH;
    endcase
  end

  assign done = (state == S_HALT);

  // R10: once halted the core stays halted
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R7: acknowledge is a single-cycle pulse
  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    intAck |=> !intAck);
  // R8: no acknowledge unless interrupts are enabled
  a_r8_ack_needs_ie: assert property (@(posedge clk) disable iff (rst)
    intAck |-> ieFlag);
endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import accPkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC    = 12'h300,
  parameter logic [ADDR_W-1:0] VECTOR      = 12'h100,
  parameter logic [ADDR_W-1:0] SP_INIT     = 12'hFFF,
  parameter logic [DATA_W-1:0] STATUS_INIT = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [OP_W-1:0]   opcode,
  output logic              ieFlag,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] statusOut
);
  logic [ADDR_W-1:0] pcReg, spReg;
  logic [DATA_W-1:0] irReg, accReg, statusReg;
  logic [DATA_W:0]   sum;

  assign sum = {1'b0, accReg} + {1'b0, memRdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg     <= RESET_PC;
      spReg     <= SP_INIT;
      irReg     <= '0;
      accReg    <= '0;
      statusReg <= STATUS_INIT;
    end else begin
      if (strb.irLoad) irReg <= memRdata;
      if (strb.pcInc)          pcReg <= pcReg + 1'b1;
      else if (strb.pcVector)  pcReg <= VECTOR;
      else if (strb.pcFromMem) pcReg <= memRdata[ADDR_W-1:0];
      if (strb.accLoad) accReg <= memRdata;
      else if (strb.accAdd) accReg <= sum[DATA_W-1:0];
      if (strb.spDec)      spReg <= spReg - 1'b1;
      else if (strb.spInc) spReg <= spReg + 1'b1;
      if (strb.statusFromMem) statusReg <= memRdata;
      else begin
        if (strb.accAdd)  statusReg[CARRY_BIT] <= sum[DATA_W];
        if (strb.ieClear) statusReg[IE_BIT]    <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (strb.addrSel)
      A_PC:    memAddr = pcReg;
      A_OPER:  memAddr = irReg[ADDR_W-1:0];
      A_SP:    memAddr = spReg;
      A_SPUP:  memAddr = spReg + 1'b1;
      default: memAddr = pcReg;
    endcase
    unique case (strb.wSel)
      W_ACC:    memWdata = accReg;
      W_PC:     memWdata = {{(DATA_W-ADDR_W){1'b0}}, pcReg};
      W_STATUS: memWdata = statusReg;
      default:  memWdata = accReg;
    endcase
  end

  assign memWe     = strb.memWe;
  assign opcode    = irReg[DATA_W-1 -: OP_W];
  assign ieFlag    = statusReg[IE_BIT];
  assign pcOut     = pcReg;
  assign accOut    = accReg;
  assign statusOut = statusReg;

  // R4: each fetch advances the PC by exactly one
  a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
    strb.pcInc |=> pcReg == $past(pcReg) + 1'b1);
  // R9: a return pops the PC from the slot above the status slot
  a_r9_pop_order: assert property (@(posedge clk) disable iff (rst)
    strb.statusFromMem |=> strb.pcFromMem);
endmodule

// File: rtl/accIrqCpu.sv
module accIrqCpu
  import accPkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h300,
  parameter logic [ADDR_W-1:0] VECTOR   = 12'h100,
  parameter logic [ADDR_W-1:0] SP_INIT  = 12'hFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] status,
  output logic              done,
  output logic              intAck
);
  strobe_t           strb;
  logic [OP_W-1:0]   opcode;
  logic              ieFlag;
  logic [ADDR_W-1:0] coreAddr, memAddr;
  logic [DATA_W-1:0] coreWdata, memWdata, memRdata;
  logic              coreWe, memWe;

  accControl u_control (
    .clk(clk), .rst(rst), .irq(irq), .opcode(opcode), .ieFlag(ieFlag),
    .strb(strb), .done(done), .intAck(intAck)
  );

  accDatapath #(.RESET_PC(RESET_PC), .VECTOR(VECTOR), .SP_INIT(SP_INIT)) u_datapath (
    .clk(clk), .rst(rst), .strb(strb), .memRdata(memRdata),
    .memAddr(coreAddr), .memWdata(coreWdata), .memWe(coreWe),
    .opcode(opcode), .ieFlag(ieFlag),
    .pcOut(pc), .accOut(acc), .statusOut(status)
  );

  assign memAddr  = rst ? loadAddr : coreAddr;
  assign memWdata = rst ? loadData : coreWdata;
  assign memWe    = rst ? loadEn   : coreWe;

  accMem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk), .we(memWe), .addr(memAddr), .wdata(memWdata), .rdata(memRdata),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  // R7: acknowledge is followed by the handler address with interrupts off
  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    intAck |=> (pc == VECTOR) && !status[IE_BIT]);
  // R10: a halted core never writes memory
  a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
    done |-> !coreWe);
endmodule

// File: tb/test_accIrqCpu.sv
module test_accIrqCpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        loadEn = 1'b0;
  logic [11:0] loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [11:0] dbgAddr = '0;
  logic [15:0] dbgData;
  logic [11:0] pc;
  logic [15:0] acc, status;
  logic        done, intAck;

  int nTotal = 0;
  int nPass  = 0;

  always #2 clk = ~clk;

  accIrqCpu i_accIrqCpu (
    .clk(clk), .rst(rst), .irq(irq), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .dbgAddr(dbgAddr), .dbgData(dbgData), .pc(pc),
    .acc(acc), .status(status), .done(done), .intAck(intAck)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nTotal++;
    if (act === exp) nPass++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst = 1'b1;
    irq = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(logic [11:0] a, logic [15:0] d);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [15:0] d);
    dbgAddr = a;
    @(negedge clk);
    d = dbgData;
  endtask

  task automatic runToDone(output int cyc);
    cyc = 0;
    rst = 1'b0;
    while (!done && cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    logic [15:0] w;
    enterReset();
    poke(12'h050, 16'hCAFE);
    @(negedge clk);
    chk("R1 pc", {4'h0, pc}, 16'h0300);
    chk("R1 acc", acc, 16'h0000);
    chk("R1 status", status, 16'h0001);
    chk("R1 done", {15'h0, done}, 16'h0000);
    chk("R1 intAck", {15'h0, intAck}, 16'h0000);
    peek(12'h050, w);
    chk("R11 preload readback", w, 16'hCAFE);
  endtask

  task automatic testBasic();
    int cyc;
    logic [15:0] w;
    logic [11:0] pcHalt;
    enterReset();
    poke(12'h300, 16'h1940); poke(12'h301, 16'h5941);
    poke(12'h302, 16'h2941); poke(12'h303, 16'hF000);
    poke(12'h940, 16'h0003); poke(12'h941, 16'h0002);
    runToDone(cyc);
    chk("R3 cycles to done", 16'(cyc), 16'd17);
    chk("R2 acc", acc, 16'h0005);
    chk("R4 pc after halt", {4'h0, pc}, 16'h0304);
    pcHalt = pc;
    repeat (5) @(negedge clk);
    chk("R10 done held", {15'h0, done}, 16'h0001);
    chk("R10 pc frozen", {4'h0, pc}, {4'h0, pcHalt});
    peek(12'h941, w);
    chk("R2 stored sum", w, 16'h0005);
  endtask

  task automatic testNopCarry();
    int cyc;
    logic [15:0] w;
    enterReset();
    poke(12'h300, 16'h1950); poke(12'h301, 16'h7123);
    poke(12'h302, 16'h5951); poke(12'h303, 16'h2952);
    poke(12'h304, 16'h1954); poke(12'h305, 16'hF000);
    poke(12'h950, 16'hFFFF); poke(12'h951, 16'h0002);
    poke(12'h954, 16'h0042); poke(12'h123, 16'h5A5A);
    runToDone(cyc);
    chk("R3 R5 cycles with no-op", 16'(cyc), 16'd26);
    chk("R6 carry kept across load", status, 16'h0003);
    chk("R6 acc after load", acc, 16'h0042);
    peek(12'h952, w);
    chk("R6 wrapped sum", w, 16'h0001);
    peek(12'h123, w);
    chk("R5 no-op left memory", w, 16'h5A5A);
  endtask

  task automatic testInterrupt();
    int edges = 0;
    int ackEdge = -1;
    int ackCount = 0;
    int holdLeft = -1;
    logic [15:0] w, stHandler;
    enterReset();
    poke(12'h300, 16'h1940); poke(12'h301, 16'h5941);
    poke(12'h302, 16'h2942); poke(12'h303, 16'hF000);
    poke(12'h940, 16'h0003); poke(12'h941, 16'h0002);
    poke(12'h100, 16'h2944); poke(12'h101, 16'hE000);
    poke(12'hFFD, 16'hBEEF);
    stHandler = 16'hFFFF;
    irq = 1'b1;
    rst = 1'b0;
    while (!done && edges < 2000) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (intAck) begin
        ackCount++;
        if (ackEdge < 0) begin
          ackEdge  = edges;
          holdLeft = 8;
        end
      end
      if (ackEdge >= 0 && edges == ackEdge + 2) stHandler = status;
      if (holdLeft > 0) begin
        holdLeft--;
        if (holdLeft == 0) irq = 1'b0;
      end
    end
    irq = 1'b0;
    chk("R7 ack edge", 16'(ackEdge), 16'd6);
    chk("R8 single ack while disabled", 16'(ackCount), 16'd1);
    chk("R7 enable cleared in handler", stHandler, 16'h0000);
    chk("R9 status restored", status, 16'h0001);
    chk("R9 resumed and halted", {4'h0, pc}, 16'h0304);
    peek(12'hFFF, w); chk("R7 pushed pc", w, 16'h0301);
    peek(12'hFFE, w); chk("R7 pushed status", w, 16'h0001);
    peek(12'hFFD, w); chk("R8 no nested push", w, 16'hBEEF);
    peek(12'h944, w); chk("R7 handler saw acc", w, 16'h0003);
    peek(12'h942, w); chk("R9 resumed sum", w, 16'h0005);
  endtask

  task automatic testHaltIrq();
    int cyc;
    logic [15:0] w;
    enterReset();
    poke(12'h300, 16'hF000);
    poke(12'hFFF, 16'h1111);
    irq = 1'b1;
    runToDone(cyc);
    chk("R3 halt cycles", 16'(cyc), 16'd3);
    repeat (6) begin
      @(negedge clk);
      if (intAck) chk("R10 ack after halt", 16'h1, 16'h0);
    end
    irq = 1'b0;
    peek(12'hFFF, w);
    chk("R10 no push after halt", w, 16'h1111);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testBasic();
    testNopCarry();
    testInterrupt();
    testHaltIrq();
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTotal++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  end
endmodule